// File: doc/BRIEF.md
# Segment Effective Base Tracker

This block keeps, for every segment register, two base addresses: the base that software last wrote (the architectural base) and the base that address generation must actually add (the effective base). Software updates bases one at a time through a write strobe, a segment select and a data word. The block also watches writes to the code segment attribute, where it tracks the code segment long bit. It receives the long-mode-active flag from outside.

Segments are split into two classes. The first `NUM_LEGACY` segment slots are the legacy data and code segments: extra, code, stack and data, in that order. Their effective base is forced to zero while the processor runs 64-bit code. All remaining slots are always-based segments, such as the two general extra segments, the task register and the interrupt and descriptor table bases. Their effective base always follows the written value.

Changing the code segment long bit is the event that moves the legacy class between its two states. A change to 1 clears the legacy effective bases. A change to 0 restores them from the architectural bases. The address generation unit reads both flattened output buses directly, one cycle after the write that changed them.

Top module: `seg_eff_base_tracker`

## Requirements
- R1: A write whose select addresses an always-based slot (index `NUM_LEGACY` or above, below `NUM_SEG`) makes both that slot's architectural and effective base equal to the written data at the next clock edge. This holds whatever the mode inputs are.
- R2: A write to a legacy slot (index below `NUM_LEGACY`) always updates its architectural base. It updates the effective base only when `long_active_i` is 0 or the tracked code segment long bit is 0. Otherwise the effective base is kept.
- R3: An attribute write (`cs_attr_wr_i`=1) with `cs_long_i`=1 while the tracked long bit is 0 sets the effective base of every legacy slot to zero at the next edge. This happens whatever the value of `long_active_i`.
- R4: An attribute write with `cs_long_i`=0 while the tracked long bit is 1 reloads the effective base of every legacy slot from its architectural base.
- R5: After an attribute write, `cs_long_o` equals the written `cs_long_i`. An attribute write that does not change the long bit leaves all bases unchanged. A cycle with neither a write nor an attribute write changes nothing.
- R6: After reset, all architectural and effective bases are zero and `cs_long_o` is 0.
- R7: When a base write and a long-bit change fall in the same cycle, the change rule uses the newly written base. A change to 1 leaves a written legacy slot's effective base at zero. A change to 0 leaves that slot's effective base equal to the written data.
- R8: A write whose select is `NUM_SEG` or above changes no base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_i | input | 1 | Base write strobe |
| base_sel_i | input | SEL_W | Segment slot index of the write (legacy slots 0..NUM_LEGACY-1) |
| base_data_i | input | BASE_W | Base value written |
| cs_attr_wr_i | input | 1 | Code segment attribute write strobe |
| cs_long_i | input | 1 | Long bit carried by the attribute write |
| long_active_i | input | 1 | Long mode active flag |
| arch_base_o | output | NUM_SEG*BASE_W | Architectural bases, slot k at bits [k*BASE_W +: BASE_W] |
| eff_base_o | output | NUM_SEG*BASE_W | Effective bases, same packing |
| cs_long_o | output | 1 | Tracked code segment long bit |

## Verification
Legacy writes are applied under all four combinations of long-active and long bit. Only the case where both are 1 must block the effective base, so this separates a correct AND-gate from one that checks only one of the flags. Attribute writes are issued as a change to 1, a change to 0 and a repeat of the current value. This tells an edge-triggered rule apart from one that reacts to the level of the long bit. Writes that coincide with a change expose which base value the change rule samples. Selects above the last slot show whether the decoder wraps around. A seeded random stream then mixes all of these against a bench reference model.

// File: rtl/seg_eff_pkg.sv
`timescale 1ns/1ps
package seg_eff_pkg;

   // how a slot's effective base is refreshed this cycle
   typedef enum logic [1:0] {
      UPD_HOLD   = 2'd0,
      UPD_ZERO   = 2'd1,
      UPD_RELOAD = 2'd2,
      UPD_WRITE  = 2'd3
   } eff_upd_e;

   // mode controls shared by every slot
   typedef struct packed {
      logic go_long;    // long bit changes 0 -> 1 this cycle
      logic go_legacy;  // long bit changes 1 -> 0 this cycle
      logic eff_allow;  // plain legacy writes may reach the effective base
   } mode_ctl_t;

endpackage

// File: rtl/seg_long_track.sv
`timescale 1ns/1ps
module seg_long_track
   import seg_eff_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cs_attr_wr_i,
   input  logic      cs_long_i,
   input  logic      long_active_i,
   output mode_ctl_t ctl_o,
   output logic      cs_long_q_o
);

   logic long_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         long_q <= 1'b0;
      else if (cs_attr_wr_i)
         long_q <= cs_long_i;
   end

   always_comb begin
      ctl_o.go_long   = cs_attr_wr_i &  cs_long_i & ~long_q;
      ctl_o.go_legacy = cs_attr_wr_i & ~cs_long_i &  long_q;
      ctl_o.eff_allow = ~long_active_i | ~long_q;
   end

   assign cs_long_q_o = long_q;

endmodule

// File: rtl/seg_wr_decode.sv
`timescale 1ns/1ps
module seg_wr_decode #(
   parameter int NUM_SEG = 10,
   parameter int SEL_W   = 4
) (
   input  logic               wr_i,
   input  logic [SEL_W-1:0]   sel_i,
   output logic [NUM_SEG-1:0] hit_o
);

   for (genvar k = 0; k < NUM_SEG; k++) begin : g_hit
      assign hit_o[k] = wr_i && (sel_i == SEL_W'(k));
   end

endmodule

// File: rtl/seg_base_slot.sv
`timescale 1ns/1ps
module seg_base_slot
   import seg_eff_pkg::*;
#(
   parameter int BASE_W = 64,
   parameter bit LEGACY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_i,
   input  logic [BASE_W-1:0] data_i,
   input  mode_ctl_t         ctl_i,
   output logic [BASE_W-1:0] arch_o,
   output logic [BASE_W-1:0] eff_o
);

   logic [BASE_W-1:0] arch_q, arch_d;
   logic [BASE_W-1:0] eff_q, eff_d;
   eff_upd_e          upd;

   assign arch_d = hit_i ? data_i : arch_q;

   if (LEGACY) begin : g_legacy
      always_comb begin
         if (ctl_i.go_long)
            upd = UPD_ZERO;
         else if (ctl_i.go_legacy)
            upd = UPD_RELOAD;
         else if (hit_i && ctl_i.eff_allow)
            upd = UPD_WRITE;
         else
            upd = UPD_HOLD;
      end
   end else begin : g_plain
      always_comb upd = hit_i ? UPD_WRITE : UPD_HOLD;
   end

   always_comb begin
      unique case (upd)
         UPD_ZERO:   eff_d = '0;
         UPD_RELOAD: eff_d = arch_d;  // new value when written this cycle
         UPD_WRITE:  eff_d = data_i;
         default:    eff_d = eff_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arch_q <= '0;
         eff_q  <= '0;
      end else begin
         arch_q <= arch_d;
         eff_q  <= eff_d;
      end
   end

   assign arch_o = arch_q;
   assign eff_o  = eff_q;

endmodule

// File: rtl/seg_eff_base_tracker.sv
`timescale 1ns/1ps
module seg_eff_base_tracker
   import seg_eff_pkg::*;
#(
   parameter int BASE_W     = 64,
   parameter int NUM_SEG    = 10,
   parameter int NUM_LEGACY = 4,
   parameter int SEL_W      = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      base_wr_i,
   input  logic [SEL_W-1:0]          base_sel_i,
   input  logic [BASE_W-1:0]         base_data_i,
   input  logic                      cs_attr_wr_i,
   input  logic                      cs_long_i,
   input  logic                      long_active_i,
   output logic [NUM_SEG*BASE_W-1:0] arch_base_o,
   output logic [NUM_SEG*BASE_W-1:0] eff_base_o,
   output logic                      cs_long_o
);

   localparam int MIN_SEL_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;

   if (BASE_W < 1 || NUM_SEG < 1) begin : g_bad_size
      $error("seg_eff_base_tracker: BASE_W and NUM_SEG must be positive");
   end
   if (NUM_LEGACY < 0 || NUM_LEGACY > NUM_SEG) begin : g_bad_legacy
      $error("seg_eff_base_tracker: NUM_LEGACY must lie in 0..NUM_SEG");
   end
   if (SEL_W < MIN_SEL_W) begin : g_bad_sel
      $error("seg_eff_base_tracker: SEL_W too narrow for NUM_SEG");
   end

   mode_ctl_t          ctl;
   logic [NUM_SEG-1:0] hit;

   seg_long_track u_long (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_attr_wr_i (cs_attr_wr_i),
      .cs_long_i    (cs_long_i),
      .long_active_i(long_active_i),
      .ctl_o        (ctl),
      .cs_long_q_o  (cs_long_o)
   );

   seg_wr_decode #(
      .NUM_SEG(NUM_SEG),
      .SEL_W  (SEL_W)
   ) u_dec (
      .wr_i (base_wr_i),
      .sel_i(base_sel_i),
      .hit_o(hit)
   );

   for (genvar k = 0; k < NUM_SEG; k++) begin : g_slot
      seg_base_slot #(
         .BASE_W(BASE_W),
         .LEGACY(k < NUM_LEGACY)
      ) u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .hit_i (hit[k]),
         .data_i(base_data_i),
         .ctl_i (ctl),
         .arch_o(arch_base_o[k*BASE_W +: BASE_W]),
         .eff_o (eff_base_o[k*BASE_W +: BASE_W])
      );
   end

endmodule

// File: rtl/seg_eff_base_chk.sv
`timescale 1ns/1ps
module seg_eff_base_chk #(
   parameter int BASE_W     = 64,
   parameter int NUM_SEG    = 10,
   parameter int NUM_LEGACY = 4,
   parameter int SEL_W      = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      base_wr_i,
   input logic [SEL_W-1:0]          base_sel_i,
   input logic [BASE_W-1:0]         base_data_i,
   input logic                      cs_attr_wr_i,
   input logic                      cs_long_i,
   input logic                      long_active_i,
   input logic [NUM_SEG*BASE_W-1:0] arch_base_o,
   input logic [NUM_SEG*BASE_W-1:0] eff_base_o,
   input logic                      cs_long_o
);

   logic flip;
   assign flip = cs_attr_wr_i && (cs_long_i != cs_long_o);

   p_long_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cs_attr_wr_i |=> (cs_long_o == $past(cs_long_i)));

   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!base_wr_i && !flip) |=> ($stable(eff_base_o) && $stable(arch_base_o)));

   p_bad_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (base_wr_i && (int'(base_sel_i) >= NUM_SEG) && !flip)
      |=> ($stable(eff_base_o) && $stable(arch_base_o)));

   for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
      p_arch_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (base_wr_i && base_sel_i == SEL_W'(k))
         |=> (arch_base_o[k*BASE_W +: BASE_W] == $past(base_data_i)));

      if (k >= NUM_LEGACY) begin : g_plain
         p_plain_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (base_wr_i && base_sel_i == SEL_W'(k))
            |=> (eff_base_o[k*BASE_W +: BASE_W] == $past(base_data_i)));
      end else begin : g_legacy
         p_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (base_wr_i && base_sel_i == SEL_W'(k) && long_active_i && cs_long_o && !cs_attr_wr_i)
            |=> $stable(eff_base_o[k*BASE_W +: BASE_W]));

         p_go_long_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cs_attr_wr_i && cs_long_i && !cs_long_o)
            |=> (eff_base_o[k*BASE_W +: BASE_W] == '0));

         p_go_legacy_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cs_attr_wr_i && !cs_long_i && cs_long_o)
            |=> (eff_base_o[k*BASE_W +: BASE_W] == arch_base_o[k*BASE_W +: BASE_W]));
      end
   end

endmodule

bind seg_eff_base_tracker seg_eff_base_chk #(
   .BASE_W    (BASE_W),
   .NUM_SEG   (NUM_SEG),
   .NUM_LEGACY(NUM_LEGACY),
   .SEL_W     (SEL_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .base_wr_i    (base_wr_i),
   .base_sel_i   (base_sel_i),
   .base_data_i  (base_data_i),
   .cs_attr_wr_i (cs_attr_wr_i),
   .cs_long_i    (cs_long_i),
   .long_active_i(long_active_i),
   .arch_base_o  (arch_base_o),
   .eff_base_o   (eff_base_o),
   .cs_long_o    (cs_long_o)
);

// File: tb/seg_eff_base_tracker_bench.sv
`timescale 1ns/1ps
module seg_eff_base_tracker_bench;

   localparam int BW = 64;
   localparam int NS = 10;
   localparam int NL = 4;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          base_wr_i;
   logic [SW-1:0] base_sel_i;
   logic [BW-1:0] base_data_i;
   logic          cs_attr_wr_i;
   logic          cs_long_i;
   logic          long_active_i;
   logic [NS*BW-1:0] arch_base_o;
   logic [NS*BW-1:0] eff_base_o;
   logic          cs_long_o;

   int checks   = 0;
   int failures = 0;
   logic long_act = 1'b0;

   logic [BW-1:0] m_arch [NS];
   logic [BW-1:0] m_eff  [NS];
   logic          m_long;

   always #2.5 clk = ~clk;

   seg_eff_base_tracker #(
      .BASE_W(BW), .NUM_SEG(NS), .NUM_LEGACY(NL), .SEL_W(SW)
   ) u_seg_eff_base_tracker (
      .clk(clk), .rst_n(rst_n),
      .base_wr_i(base_wr_i), .base_sel_i(base_sel_i), .base_data_i(base_data_i),
      .cs_attr_wr_i(cs_attr_wr_i), .cs_long_i(cs_long_i), .long_active_i(long_active_i),
      .arch_base_o(arch_base_o), .eff_base_o(eff_base_o), .cs_long_o(cs_long_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [BW-1:0] act, input logic [BW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   // reference model built from the requirements
   task automatic model(input logic we, input logic [SW-1:0] sel, input logic [BW-1:0] d,
                        input logic aw, input logic an, input logic la);
      logic allow, up, down;
      allow = !la || !m_long;
      up    = aw && an && !m_long;
      down  = aw && !an && m_long;
      if (we && int'(sel) < NS) begin
         m_arch[sel] = d;
         if (int'(sel) >= NL || allow) m_eff[sel] = d;
      end
      for (int k = 0; k < NL; k++) begin
         if (up)   m_eff[k] = '0;
         if (down) m_eff[k] = m_arch[k];
      end
      if (aw) m_long = an;
   endtask

   task automatic compare_all(input string req);
      for (int k = 0; k < NS; k++) begin
         check(arch_base_o[k*BW +: BW] == m_arch[k], req, $sformatf("arch seg%0d", k),
               arch_base_o[k*BW +: BW], m_arch[k]);
         check(eff_base_o[k*BW +: BW] == m_eff[k], req, $sformatf("eff seg%0d", k),
               eff_base_o[k*BW +: BW], m_eff[k]);
      end
      check(cs_long_o == m_long, req, "cs_long", BW'(cs_long_o), BW'(m_long));
   endtask

   task automatic step(input logic we, input logic [SW-1:0] sel, input logic [BW-1:0] d,
                       input logic aw, input logic an, input logic la, input string req);
      @(negedge clk);
      base_wr_i     = we;
      base_sel_i    = sel;
      base_data_i   = d;
      cs_attr_wr_i  = aw;
      cs_long_i     = an;
      long_active_i = la;
      @(posedge clk);
      model(we, sel, d, aw, an, la);
      #1;
      compare_all(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      rst_n = 1'b0;
      base_wr_i = 0; base_sel_i = '0; base_data_i = '0;
      cs_attr_wr_i = 0; cs_long_i = 0; long_active_i = 0;
      for (int k = 0; k < NS; k++) begin m_arch[k] = '0; m_eff[k] = '0; end
      m_long = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      compare_all("R6");

      // R2/R1: fill every slot in legacy mode
      for (int k = 0; k < NS; k++)
         step(1, SW'(k), 64'h1111_0000_0000_0000 + 64'(k) * 64'h101, 0, 0, 0, k < NL ? "R2" : "R1");
      // R3: change to long while long-active is low, then raise long-active
      step(0, '0, '0, 1, 1, 0, "R3");
      // R2 blocked, R1 always-based
      step(1, SW'(2), 64'hDEAD_BEEF_0000_0002, 0, 0, 1, "R2");
      step(1, SW'(5), 64'hCAFE_0000_0000_0005, 0, 0, 1, "R1");
      // R5: repeat long bit, nothing changes
      step(0, '0, '0, 1, 1, 1, "R5");
      step(0, '0, '0, 0, 0, 1, "R5");
      // R2: long-active low with long bit set lets the write through
      step(1, SW'(1), 64'h0000_1234_5678_0001, 0, 0, 0, "R2");
      // R4: leave long, reload from architectural
      step(0, '0, '0, 1, 0, 1, "R4");
      // R2: long-active high, long bit low lets it through
      step(1, SW'(3), 64'h3333_3333_0000_0003, 0, 0, 1, "R2");
      // R7: write and change to long in one cycle
      step(1, SW'(3), 64'h7777_0000_0000_0003, 1, 1, 1, "R7");
      // R7: write and change to legacy in one cycle
      step(1, SW'(0), 64'h7000_0000_0000_0A00, 1, 0, 1, "R7");
      // R8: select beyond the last slot
      step(1, SW'(12), 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R8");
      step(1, SW'(15), 64'hEEEE_EEEE_EEEE_EEEE, 0, 0, 1, "R8");

      for (int i = 0; i < 3000; i++) begin
         logic we, aw, an;
         logic [SW-1:0] sel;
         logic [BW-1:0] d;
         we  = ($urandom % 10) < 6;
         sel = SW'($urandom % 16);
         d   = {$urandom, $urandom};
         aw  = ($urandom % 10) < 2;
         an  = $urandom % 2;
         if (($urandom % 10) == 0) long_act = ~long_act;
         step(we, sel, d, aw, an, long_act, "RAND R1 R2 R3 R4 R7");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule